// File: doc/BRIEF.md
# Aperture Page Remapping Table Translator

This block converts bus addresses that land inside a 256 MB graphics aperture window into system physical addresses. Each 4 KB page of the window has one 32-bit entry in a remapping table that lives in system memory. The table is stored little-endian, so every fetched word is byte-swapped before use. The upper twenty bits of the swapped word hold the physical page number, and bit 0 marks the entry as usable. Recently used entries are held in a small fully associative translation buffer, so repeated accesses to a page skip the memory fetch.

Software programs three registers. The first is a table register that packs the page-aligned table address with the number of mapped pages. The second is an aperture register, of which only the top nibble counts. The third is a control register. Flushing the buffer is not a separate command: writing the control register with its invalidate bit set empties the buffer. Bring-up and shutdown are sequences of such control writes, and software may wait on the idle output before it starts a shutdown. The block handles one translation at a time and issues at most one table read at a time.

Top module: `aperture_xlate`

## Requirements
- R1: After reset every register reads as zero, `idle` and `req_ready` are 1, and `rsp_valid` and `mem_req` are 0.
- R2: Register offset 0 holds the table word: bits 31:12 are the table address page and bits 11:0 are the page count; it reads back as written. Offset 1 keeps only bits 31:28 and reads zero below them. Offset 2 keeps enable at bit 8 and the bad-entry option at bit 17. Its invalidate (bit 0) and reset (bit 16) strobes always read as 0.
- R3: A request accepted while enable is 0 gets a fault response with address 0 on the next cycle, and no table read is made.
- R4: A request whose address bits 31:28 differ from the aperture nibble, or whose page index (address bits 27:12) is not below the page count, gets a fault response on the next cycle without a table read.
- R5: On a buffer miss exactly one table read is issued, at table address + index*4. The fetched word is byte-swapped, and the response arrives on the cycle after `mem_ack`. It carries the swapped word's bits 31:12 followed by the request's low 12 address bits.
- R6: A swapped entry with bit 0 clear gives a fault with address 0 and is not cached, so the same page fetches again next time.
- R7: A request that hits the buffer responds on the cycle after acceptance with no table read.
- R8: Every control write with bit 0 set empties the buffer, however many have come before. The next request to any page fetches again.
- R9: The buffer holds four pages and replaces them in fill order, so a fifth distinct page evicts the oldest fill.
- R10: `idle` (and `req_ready`) is 0 from request acceptance on a miss until the fetch completes, and 1 otherwise. `mem_req` is never high while idle.
- R11: If an invalidate lands while a fetch is outstanding, the fetched translation is still returned but is not cached.
- R12: After the shutdown writes (enable with invalidate, 0, reset strobe, 0), the control register reads 0 and requests fault without table reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 table, 1 aperture, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Aperture bus address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| mem_req | output | 1 | Table read request, held until acknowledged |
| mem_addr | output | 32 | Table entry address |
| mem_ack | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Raw little-endian table word |
| idle | output | 1 | No translation or fetch in flight |

## Verification
The assertions take for granted that `mem_ack` is a single-cycle pulse that only comes while `mem_req` is high, and that `req_valid` is raised only when `req_ready` is 1. The behavioural memory in the bench answers each read exactly once, a fixed three cycles after it first sees the request. Every request task waits for the previous response and drops `req_valid` after a single accepted cycle. The table sits inside a 64-word model region, and every tested index is kept within it.

// File: rtl/apx_pkg.sv
// Package: shared constants, state type and helpers for the aperture translator.
// Assumes 32-bit bus addresses and 32-bit table entries.
package apx_pkg;
    localparam int AW = 32;
    localparam int WIN_BITS = 4;

    localparam logic [1:0] RSEL_TABLE = 2'd0;
    localparam logic [1:0] RSEL_APER  = 2'd1;
    localparam logic [1:0] RSEL_CTRL  = 2'd2;

    localparam int CB_INVAL  = 0;
    localparam int CB_ENABLE = 8;
    localparam int CB_RESET  = 16;
    localparam int CB_BADOPT = 17;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_FETCH = 1'b1} xl_state_t;

    // Reverse byte order of a little-endian word read from memory.
    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/apx_regs.sv
// Module: register file for the translator.
// Holds the table word, the aperture nibble and the control bits. It
// produces a one-cycle flush pulse whenever control is written with the
// invalidate bit set. Assumes a single write port and a combinational read.
module apx_regs
    import apx_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [1:0]              sel,
    input  logic [AW-1:0]           wdata,
    output logic [AW-1:0]           rdata,
    output logic [AW-PAGE_BITS-1:0] tbl_page,
    output logic [PAGE_BITS-1:0]    tbl_count,
    output logic [WIN_BITS-1:0]     win_top,
    output logic                    enable,
    output logic                    flush
);
    logic bad_opt;

    // Store register fields on writes; strobes are not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_page  <= '0;
            tbl_count <= '0;
            win_top   <= '0;
            enable    <= 1'b0;
            bad_opt   <= 1'b0;
        end else if (we) begin
            case (sel)
                RSEL_TABLE: {tbl_page, tbl_count} <= wdata;
                RSEL_APER:  win_top <= wdata[AW-1 -: WIN_BITS];
                RSEL_CTRL: begin
                    enable  <= wdata[CB_ENABLE];
                    bad_opt <= wdata[CB_BADOPT];
                end
                default: ;
            endcase
        end
    end

    // Invalidate strobe: any control write carrying bit 0.
    assign flush = we && (sel == RSEL_CTRL) && wdata[CB_INVAL];

    // Read multiplexer; strobe positions always read zero.
    always_comb begin
        rdata = '0;
        case (sel)
            RSEL_TABLE: rdata = {tbl_page, tbl_count};
            RSEL_APER:  rdata[AW-1 -: WIN_BITS] = win_top;
            RSEL_CTRL: begin
                rdata[CB_ENABLE] = enable;
                rdata[CB_BADOPT] = bad_opt;
            end
            default: ;
        endcase
    end

    AST_APER_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RSEL_APER) |-> (rdata[AW-WIN_BITS-1:0] == '0)); // R2
    AST_STROBES_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RSEL_CTRL) |-> (!rdata[CB_INVAL] && !rdata[CB_RESET])); // R2
    AST_ENABLE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == RSEL_CTRL) |=> (enable == $past(wdata[CB_ENABLE]))); // R12
endmodule

// File: rtl/apx_tlb.sv
// Module: fully associative translation buffer.
// Maps page index tags to physical page numbers. Lookup is combinational.
// Fills go round-robin in fill order, and flush empties every slot.
// Assumes the caller never inserts a tag that is already present.
module apx_tlb #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 16,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             ins_en,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [PPN_W-1:0] ins_ppn
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] valid;
    logic [DEPTH-1:0] match;
    logic [TAG_W-1:0] tags [DEPTH];
    logic [PPN_W-1:0] ppns [DEPTH];
    logic [PTR_W-1:0] fill_ptr;

    // Per-slot tag comparators.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == lk_tag);
    end

    // OR-combine the matching slot's page number.
    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_ppn = hit_ppn | ppns[i];
        end
    end
    assign hit = |match;

    // Slot valid bits and fill pointer; flush wins over a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= '0;
            fill_ptr <= '0;
        end else if (flush) begin
            valid    <= '0;
            fill_ptr <= '0;
        end else if (ins_en) begin
            valid[fill_ptr] <= 1'b1;
            fill_ptr <= (fill_ptr == PTR_W'(DEPTH - 1)) ? '0 : fill_ptr + 1'b1;
        end
    end

    // Slot payload storage, written on fills.
    always_ff @(posedge clk) begin
        if (ins_en && !flush) begin
            tags[fill_ptr] <= ins_tag;
            ppns[fill_ptr] <= ins_ppn;
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid == '0)); // R8
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R9
endmodule

// File: rtl/aperture_xlate.sv
// Module: aperture page remapping translator (top).
// Accepts one request at a time. It faults when disabled or out of range,
// answers buffer hits one cycle later, and fetches the table entry on a
// miss. Assumes mem_ack is a one-cycle pulse given only while mem_req is high.
module aperture_xlate
    import apx_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int TLB_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          idle
);
    localparam int IDX_W = AW - WIN_BITS - PAGE_BITS;
    localparam int PPN_W = AW - PAGE_BITS;

    logic [PPN_W-1:0]     tbl_page;
    logic [PAGE_BITS-1:0] tbl_count;
    logic [WIN_BITS-1:0]  win_top;
    logic                 enable, flush;

    apx_regs #(.PAGE_BITS(PAGE_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .tbl_page(tbl_page),
        .tbl_count(tbl_count), .win_top(win_top), .enable(enable),
        .flush(flush)
    );

    xl_state_t            state;
    logic [IDX_W-1:0]     idx, idx_q;
    logic [PAGE_BITS-1:0] off_q;
    logic                 stale_q;
    logic                 in_range, accept, tlb_hit, ins_en;
    logic [PPN_W-1:0]     hit_ppn;
    logic [AW-1:0]        entry;
    logic                 unused_entry_bits;

    assign idx      = req_addr[AW-WIN_BITS-1:PAGE_BITS];
    assign in_range = (req_addr[AW-1 -: WIN_BITS] == win_top) &&
                      (idx < IDX_W'(tbl_count));
    assign accept   = req_valid && (state == ST_IDLE);
    assign entry    = swap_bytes(mem_rdata);
    assign unused_entry_bits = ^entry[PAGE_BITS-1:1];
    assign ins_en   = (state == ST_FETCH) && mem_ack && entry[0] && !stale_q && !flush;

    apx_tlb #(.DEPTH(TLB_DEPTH), .TAG_W(IDX_W), .PPN_W(PPN_W)) u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_tag(idx),
        .hit(tlb_hit), .hit_ppn(hit_ppn), .ins_en(ins_en),
        .ins_tag(idx_q), .ins_ppn(entry[AW-1:PAGE_BITS])
    );

    // Request sequencing: classify on accept, fetch on a miss, respond once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            idx_q     <= '0;
            off_q     <= '0;
            stale_q   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                if (!enable || !in_range) begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= 1'b1;
                    rsp_paddr <= '0;
                end else if (tlb_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= 1'b0;
                    rsp_paddr <= {hit_ppn, req_addr[PAGE_BITS-1:0]};
                end else begin
                    state    <= ST_FETCH;
                    mem_req  <= 1'b1;
                    mem_addr <= {tbl_page, {PAGE_BITS{1'b0}}} + AW'({idx, 2'b00});
                    idx_q    <= idx;
                    off_q    <= req_addr[PAGE_BITS-1:0];
                    stale_q  <= 1'b0;
                end
            end else if (state == ST_FETCH) begin
                if (flush) stale_q <= 1'b1;
                if (mem_ack) begin
                    state     <= ST_IDLE;
                    mem_req   <= 1'b0;
                    rsp_valid <= 1'b1;
                    rsp_fault <= !entry[0];
                    rsp_paddr <= entry[0] ? {entry[AW-1:PAGE_BITS], off_q} : '0;
                end
            end
        end
    end

    assign idle      = (state == ST_IDLE);
    assign req_ready = idle;

    AST_OFF_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !enable) |=> (!mem_req && rsp_valid && rsp_fault)); // R3
    AST_RANGE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_range) |=> (!mem_req && rsp_fault)); // R4
    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R5
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R6
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && enable && in_range && tlb_hit) |=> (rsp_valid && !rsp_fault && !mem_req)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_req); // R10
endmodule

// File: tb/tb_aperture_xlate.sv
`timescale 1ns/1ps
module tb_aperture_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        idle;

    int checks = 0;
    int failures = 0;
    int mem_reads = 0;
    int cycles = 0;
    logic [31:0] last_maddr = '0;
    logic [31:0] tmem [64];
    int          lat_cnt = 0;

    always #2 clk = ~clk;

    aperture_xlate dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .idle(idle)
    );

    function automatic logic [31:0] le(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // Behavioural memory: acknowledges three cycles after seeing a request.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req) begin
            if (lat_cnt == 2) begin
                mem_ack    <= 1'b1;
                mem_rdata  <= tmem[mem_addr[7:2]];
                last_maddr <= mem_addr;
                mem_reads  <= mem_reads + 1;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic xlate(input logic [31:0] a, input bit fmid, output logic f,
                         output logic [31:0] pa, output int lat, output int nr,
                         output bit busy);
        int r0;
        r0 = mem_reads;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (fmid) begin
            reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_0101;
        end
        lat = 0; busy = 1'b0;
        while (!rsp_valid && lat < 60) begin
            if (!idle) busy = 1'b1;
            @(negedge clk);
            reg_we = 1'b0;
            lat++;
        end
        f = rsp_fault; pa = rsp_paddr; nr = mem_reads - r0;
        if (!rsp_valid) chk("R10 response timeout", 32'd0, 32'd1);
    endtask

    // addr[65:34], fault[33], paddr[32:1], one table read expected[0]
    localparam logic [65:0] VEC [8] = '{
        {32'h8000_3123, 1'b0, 32'hA000_3123, 1'b1},
        {32'h8000_3FFC, 1'b0, 32'hA000_3FFC, 1'b0},
        {32'h8000_5000, 1'b1, 32'h0000_0000, 1'b1},
        {32'h8000_5004, 1'b1, 32'h0000_0000, 1'b1},
        {32'h8001_0000, 1'b1, 32'h0000_0000, 1'b0},
        {32'h9000_3000, 1'b1, 32'h0000_0000, 1'b0},
        {32'h8000_F00A, 1'b0, 32'hA000_F00A, 1'b1},
        {32'h8000_0000, 1'b0, 32'hA000_0000, 1'b1}
    };

    initial begin
        logic        f;
        logic [31:0] pa, d;
        int          lat, nr;
        bit          busy;

        for (int i = 0; i < 64; i++)
            tmem[i] = le({20'hA0000 + 20'(i), 11'd0, (i != 5)});

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", 32'(idle), 32'd1);
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        rd(2'd0, d); chk("R1 table reg", d, 32'd0);
        rd(2'd2, d); chk("R1 ctrl reg", d, 32'd0);

        wr(2'd0, 32'h0001_0010);
        wr(2'd1, 32'h8123_4567);
        xlate(32'h8000_3000, 0, f, pa, lat, nr, busy);
        chk("R3 fault while disabled", 32'(f), 32'd1);
        chk("R3 no read while disabled", 32'(nr), 32'd0);
        chk("R3 zero address", pa, 32'd0);

        rd(2'd0, d); chk("R2 table readback", d, 32'h0001_0010);
        rd(2'd1, d); chk("R2 aperture nibble only", d, 32'h8000_0000);
        wr(2'd2, 32'h0003_0101);
        rd(2'd2, d); chk("R2 ctrl strobes read zero", d, 32'h0002_0100);

        wr(2'd2, 32'h0000_0101);
        wr(2'd2, 32'h0000_0100);
        wr(2'd2, 32'h0001_0100);
        wr(2'd2, 32'h0000_0100);
        rd(2'd2, d); chk("R2 enabled ctrl", d, 32'h0000_0100);

        for (int v = 0; v < 8; v++) begin
            xlate(VEC[v][65:34], 0, f, pa, lat, nr, busy);
            chk($sformatf("R4/R5/R6 vec%0d fault", v), 32'(f), 32'(VEC[v][33]));
            chk($sformatf("R5/R7 vec%0d paddr", v), pa, VEC[v][32:1]);
            chk($sformatf("R5/R6/R7 vec%0d reads", v), 32'(nr), 32'(VEC[v][0]));
            if (VEC[v][0]) begin
                chk($sformatf("R5 vec%0d table addr", v), last_maddr,
                    32'h0001_0000 + {16'd0, VEC[v][61:46], 2'b00});
                chk($sformatf("R10 vec%0d busy during fetch", v), 32'(busy), 32'd1);
            end else begin
                chk($sformatf("R7 vec%0d next-cycle", v), 32'(lat), 32'd0);
            end
        end

        // R9: fill idx1, idx2; idx3 (oldest) is evicted, idx15 survives.
        xlate(32'h8000_1000, 0, f, pa, lat, nr, busy);
        xlate(32'h8000_2000, 0, f, pa, lat, nr, busy);
        xlate(32'h8000_F000, 0, f, pa, lat, nr, busy);
        chk("R9 survivor hits", 32'(nr), 32'd0);
        xlate(32'h8000_3000, 0, f, pa, lat, nr, busy);
        chk("R9 oldest evicted", 32'(nr), 32'd1);
        chk("R9 refetched paddr", pa, 32'hA000_3000);

        // R8: repeated invalidates each empty the buffer.
        xlate(32'h8000_0040, 0, f, pa, lat, nr, busy);
        chk("R8 cached before flush", 32'(nr), 32'd0);
        wr(2'd2, 32'h0000_0101);
        xlate(32'h8000_0040, 0, f, pa, lat, nr, busy);
        chk("R8 miss after first flush", 32'(nr), 32'd1);
        xlate(32'h8000_0040, 0, f, pa, lat, nr, busy);
        chk("R8 refilled", 32'(nr), 32'd0);
        wr(2'd2, 32'h0000_0100);
        wr(2'd2, 32'h0000_0101);
        xlate(32'h8000_0040, 0, f, pa, lat, nr, busy);
        chk("R8 miss after second flush", 32'(nr), 32'd1);

        // R11: invalidate during fetch returns data but does not cache it.
        xlate(32'h8000_7ABC, 1, f, pa, lat, nr, busy);
        chk("R11 paddr despite flush", pa, 32'hA000_7ABC);
        chk("R11 fault flag", 32'(f), 32'd0);
        xlate(32'h8000_7000, 0, f, pa, lat, nr, busy);
        chk("R11 not cached", 32'(nr), 32'd1);

        // R12: shutdown sequence.
        @(negedge clk);
        chk("R10 idle before shutdown", 32'(idle), 32'd1);
        wr(2'd2, 32'h0000_0101);
        wr(2'd2, 32'h0000_0000);
        wr(2'd2, 32'h0001_0000);
        wr(2'd2, 32'h0000_0000);
        rd(2'd2, d); chk("R12 ctrl cleared", d, 32'd0);
        xlate(32'h8000_7000, 0, f, pa, lat, nr, busy);
        chk("R12 fault after shutdown", 32'(f), 32'd1);
        chk("R12 no read after shutdown", 32'(nr), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule